// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It watches a free-running counter value that arrives from outside the block, and it has one external pin in each direction. In input capture mode, a chosen edge on the input pin copies the current counter value into the channel value register. In output compare mode, the output pin is set, cleared or toggled when the counter reaches the channel value. A PWM mode works in the same way as compare mode, and it can also hold the output at constant high for 100% duty. A separate control bit toggles the output on each counter overflow.

Each capture or compare event sets an event flag. The flag drives an interrupt request when its enable bit is on. Software clears the flag with a two-step handshake. First it reads the status register while the flag is 1, which arms the clear. Then it writes 0 to the flag bit. If any new event arrives after the arming read, the arm is dropped and the flag stays set. This means a request can never be lost because software cleared the flag at the wrong time.

Software reaches the channel through a byte-wide register port with separate read and write strobes and a 2-bit address. The status register is at address 0. The channel value is at address 1 (high byte) and address 2 (low byte).

Top module: `tmr_chan`

## Requirements
- R1: After reset, every status bit reads 0. The channel value reads 0 in both bytes. `pin_o` and `irq_o` are both 0.
- R2: The status register is at address 0. Its bits, from bit 7 down to bit 0, are:
  - bit 7: flag
  - bit 6: interrupt enable
  - bit 5: mode B
  - bit 4: mode A
  - bit 3: edge B
  - bit 2: edge A
  - bit 1: overflow toggle
  - bit 0: max duty

  Bits 6..0 read back as written. Address 1 returns the high byte of the channel value and address 2 the low byte, and both are writable. Address 3 reads 0.
- R3: Mode bits {B,A}=00 select capture mode, and the edge bits then pick the active edge: 01 rising, 10 falling, 11 either. The input pin passes through two synchronizer flops. The resulting edge sets the flag and loads the counter into the channel value in the same clock, three clocks after the pin changes.
- R4: When both edge bits are 00, no event occurs in any mode. The flag is not set and the channel value is not loaded.
- R5: Mode 01 selects compare mode. The match event happens when the counter has just changed to a value equal to the channel value. A match sets the flag once and applies the edge-bit action to `pin_o`: 01 toggle, 10 clear, 11 set. Holding the counter at the matching value repeats nothing.
- R6: With the overflow-toggle bit set in compare or PWM mode, an `ovf_i` pulse toggles `pin_o` and does not set the flag. A match in the same clock takes priority over the overflow toggle.
- R7: Mode 1x selects PWM. With the max-duty bit at 0 it behaves as compare mode. With the max-duty bit at 1, `pin_o` is forced to 1 whatever matches occur.
- R8: In capture mode, `pin_o` holds its value.
- R9: `irq_o` is 1 exactly while the flag and the interrupt enable are both 1.
- R10: Writing 1 to the flag bit never changes the flag. Writing 0 to the flag bit without a preceding arming read leaves the flag set. Any write to the status register drops the arm.
- R11: A status read that sees the flag at 1, followed by a status write with bit 7 at 0, clears the flag.
- R12: An event that arrives after the arming read, or in the same clock as the clearing write, leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| ovf_i | input | 1 | One-clock pulse when the counter wraps |
| pin_i | input | 1 | Channel input pin (asynchronous) |
| pin_o | output | 1 | Channel output pin |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational while `rd_i` is high, 0 otherwise) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the race of R12: an event landing after the arming read but before, or exactly on, the clearing write. Because capture has a fixed three-clock latency through the synchronizer, the stimulus can place it precisely. It toggles the input pin in a chosen cycle relative to the read strobe. The event then lands either one cycle before the clearing write or in the same cycle as it. The pin-based flag checks in R10 use `irq_o` with the interrupt enable set, so the flag is observed without a read that would arm the clear.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  // Register addresses
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_VHI  = 2'd1;
  localparam logic [1:0] A_VLO  = 2'd2;

  // Mode bits {B,A}
  localparam logic [1:0] MD_CAPT = 2'b00;
  localparam logic [1:0] MD_CMP  = 2'b01;

  // Compare actions selected by the edge bits
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } cmp_act_t;

  // Control part of the status register, bits 6..0
  typedef struct packed {
    logic       ie;
    logic [1:0] mode;
    logic [1:0] edg;
    logic       tov;
    logic       maxd;
  } ctl_t;

endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
  assign fall_o = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wflag_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_n;
  logic armed_q, armed_n;

  always_comb begin
    flag_n  = flag_q;
    armed_n = armed_q;
    if (evt_i) begin
      // a fresh event always wins and cancels a pending clear
      flag_n  = 1'b1;
      armed_n = 1'b0;
    end else if (wr_stat_i) begin
      if (armed_q && !wflag_i) flag_n = 1'b0;
      armed_n = 1'b0;
    end else if (rd_stat_i && flag_q) begin
      armed_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      armed_q <= armed_n;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [1:0] edg_i,
  input  logic       tov_i,
  input  logic       maxd_i,
  input  logic       match_i,
  input  logic       ovf_i,
  output logic       pin_o
);
  logic pin_q, pin_n;

  always_comb begin
    pin_n = pin_q;
    if (mode_i != MD_CAPT) begin
      if (mode_i[1] && maxd_i) begin
        pin_n = 1'b1;
      end else if (match_i) begin
        case (cmp_act_t'(edg_i))
          ACT_TOG: pin_n = ~pin_q;
          ACT_CLR: pin_n = 1'b0;
          ACT_SET: pin_n = 1'b1;
          default: pin_n = pin_q;
        endcase
      end else if (ovf_i && tov_i) begin
        pin_n = ~pin_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_n;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_MODE_B  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             pin_i,
  output logic             pin_o,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o
);
  localparam int         HI_W     = CNT_W - 8;
  localparam logic [6:0] CTL_MASK = HAS_MODE_B ? 7'h7F : 7'h5F;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // bus decode
  logic rd_stat, wr_stat, wr_hi, wr_lo;
  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_hi   = wr_i && (addr_i == A_VHI);
  assign wr_lo   = wr_i && (addr_i == A_VLO);

  // control register
  ctl_t ctl_q, ctl_n;
  always_comb begin
    ctl_n = ctl_q;
    if (wr_stat) ctl_n = ctl_t'(wdata_i[6:0] & CTL_MASK);
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctl_q <= '0;
    else if (wr_stat) ctl_q <= ctl_n;
  end

  logic [1:0] mode;
  logic [1:0] edg;
  logic       tov, maxd;
  assign mode = ctl_q.mode;
  assign edg  = ctl_q.edg;
  assign tov  = ctl_q.tov;
  assign maxd = ctl_q.maxd;

  // input edge detection
  logic rise, fall, edge_hit;
  tmr_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );
  assign edge_hit = (mode == MD_CAPT) && ((edg[0] && rise) || (edg[1] && fall));

  // counter tracking for arrival-based match
  logic [CNT_W-1:0] cnt_q, val_q, val_n;
  logic             cnt_moved, match, evt, val_en;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cnt_q <= '0;
    else            cnt_q <= cnt_i;
  end
  assign cnt_moved = (cnt_i != cnt_q);
  assign match     = (mode != MD_CAPT) && (edg != 2'b00) && cnt_moved && (cnt_i == val_q);
  assign evt       = edge_hit || match;

  // channel value register
  always_comb begin
    val_n = val_q;
    if (wr_hi) val_n[CNT_W-1:8] = wdata_i[HI_W-1:0];
    if (wr_lo) val_n[7:0] = wdata_i;
    if (edge_hit) val_n = cnt_i;
  end
  assign val_en = wr_hi || wr_lo || edge_hit;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  val_q <= '0;
    else if (val_en) val_q <= val_n;
  end

  // flag with guarded clear
  logic flag_q, armed_q;
  tmr_chan_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt_i     (evt),
    .rd_stat_i (rd_stat),
    .wr_stat_i (wr_stat),
    .wflag_i   (wdata_i[7]),
    .flag_o    (flag_q),
    .armed_o   (armed_q)
  );

  // output pin
  tmr_chan_out u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode_i  (mode),
    .edg_i   (edg),
    .tov_i   (tov),
    .maxd_i  (maxd),
    .match_i (match),
    .ovf_i   (ovf_i),
    .pin_o   (pin_o)
  );

  // read mux
  logic [7:0] rd_mux;
  always_comb begin
    case (addr_i)
      A_STAT:  rd_mux = {flag_q, ctl_q};
      A_VHI:   rd_mux = 8'(val_q >> 8);
      A_VLO:   rd_mux = val_q[7:0];
      default: rd_mux = 8'h00;
    endcase
  end
  assign rdata_o = rd_i ? rd_mux : 8'h00;
  assign irq_o   = flag_q && ctl_q.ie;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] val,
  input logic             evt,
  input logic             cap_hit,
  input logic             flag,
  input logic             armed,
  input logic             wr_stat,
  input logic             wbit7,
  input logic [1:0]       mode,
  input logic             maxd,
  input logic             pin_o,
  input logic             irq_o
);
  // R3 and R5: an event always leaves the flag set
  p_evt_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  p_cap_loads_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (val == $past(cnt_i)));

  p_write_one_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_stat && wbit7) |=> flag);

  p_unarmed_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);

  p_clear_via_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && wr_stat && !wbit7));

  p_max_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && maxd) |=> pin_o);

  p_capt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> $stable(pin_o));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .cnt_i   (cnt_i),
  .val     (val_q),
  .evt     (evt),
  .cap_hit (edge_hit),
  .flag    (flag_q),
  .armed   (armed_q),
  .wr_stat (wr_stat),
  .wbit7   (wdata_i[7]),
  .mode    (mode),
  .maxd    (maxd),
  .pin_o   (pin_o),
  .irq_o   (irq_o)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt;
  logic        ovf, pin, rd, wr;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        pin_o, irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic exp_pin;

  always #10 clk = ~clk;

  tmr_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .ovf_i(ovf), .pin_i(pin), .pin_o(pin_o),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_val(output logic [15:0] v);
    logic [7:0] h, l;
    rd_reg(2'd1, h);
    rd_reg(2'd2, l);
    v = {h, l};
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd_reg(2'd0, d);
    wr_reg(2'd0, {1'b0, d[6:0]});
  endtask

  function automatic logic cmp_act(input logic p, input logic [1:0] e);
    case (e)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  function automatic logic cap_hit(input logic old_p, input logic new_p, input logic [1:0] e);
    return (!old_p && new_p && e[0]) || (old_p && !new_p && e[1]);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v, v_old;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cnt = '0; ovf = 0; pin = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd_reg(2'd0, d); chk("R1", "status", {8'h0, d}, 16'h0);
    rd_val(v);       chk("R1", "value", v, 16'h0);
    chk("R1", "pin_o", {15'h0, pin_o}, 16'h0);
    chk("R1", "irq_o", {15'h0, irq_o}, 16'h0);
    exp_pin = 1'b0;

    // R2 register access, R10 write-one, R7 max duty
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, d); chk("R2", "status readback (R10 flag write 1 ignored)", {8'h0, d}, 16'h007F);
    chk("R7", "max duty forces pin", {15'h0, pin_o}, 16'h1);
    exp_pin = 1'b1;
    wr_reg(2'd0, 8'h00);
    idle(2);
    chk("R8", "capture mode holds pin", {15'h0, pin_o}, {15'h0, exp_pin});
    wr_reg(2'd1, 8'hA5); wr_reg(2'd2, 8'h3C);
    rd_val(v); chk("R2", "value readback", v, 16'hA53C);
    rd_reg(2'd3, d); chk("R2", "unused address", {8'h0, d}, 16'h0);

    // R3 directed capture, rising edge
    cnt = 16'h1234;
    wr_reg(2'd0, 8'h04);
    pin = 1'b1;
    idle(3);
    rd_reg(2'd0, d); chk("R3", "rising capture flag", {8'h0, d}, 16'h0084);
    rd_val(v); chk("R3", "captured counter", v, 16'h1234);
    chk("R9", "irq off without enable", {15'h0, irq_o}, 16'h0);
    wr_reg(2'd0, 8'h04);
    rd_reg(2'd0, d); chk("R11", "flag cleared", {8'h0, d}, 16'h0004);

    // R3 falling edge ignored when rising selected
    cnt = 16'h5555; pin = 1'b0;
    idle(3);
    rd_reg(2'd0, d); chk("R3", "falling ignored flag", {15'h0, d[7]}, 16'h0);
    rd_val(v); chk("R3", "no capture on wrong edge", v, 16'h1234);

    // R4 edge bits 00 disable capture
    wr_reg(2'd0, 8'h00);
    cnt = 16'h6666; pin = 1'b1;
    idle(3);
    rd_reg(2'd0, d); chk("R4", "no flag with edges off", {15'h0, d[7]}, 16'h0);
    rd_val(v); chk("R4", "no capture with edges off", v, 16'h1234);

    // R3 random capture patterns
    v_old = 16'h1234;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] e;
      logic       hit;
      e = 2'($urandom_range(1, 3));
      wr_reg(2'd0, {4'h0, e, 2'b00});
      hit = cap_hit(pin, ~pin, e);
      cnt = 16'($urandom);
      pin = ~pin;
      idle(3);
      rd_reg(2'd0, d); chk("R3", "random capture flag", {15'h0, d[7]}, {15'h0, hit});
      rd_val(v);
      if (hit) v_old = cnt;
      chk("R3", "random capture value", v, v_old);
      if (hit) wr_reg(2'd0, {4'h0, e, 2'b00});
    end

    // R5 random compare patterns
    for (int i = 0; i < 16; i++) begin
      logic [1:0] e;
      e = 2'($urandom_range(1, 3));
      v = 16'($urandom);
      wr_reg(2'd0, 8'h00);
      cnt = v - 16'd1;
      idle(1);
      wr_reg(2'd1, v[15:8]); wr_reg(2'd2, v[7:0]);
      wr_reg(2'd0, {4'h1, e, 2'b00});
      cnt = v;
      idle(1);
      exp_pin = cmp_act(exp_pin, e);
      chk("R5", "compare action", {15'h0, pin_o}, {15'h0, exp_pin});
      idle(2);
      chk("R5", "held match acts once", {15'h0, pin_o}, {15'h0, exp_pin});
      rd_reg(2'd0, d); chk("R5", "compare flag", {15'h0, d[7]}, 16'h1);
      wr_reg(2'd0, {1'b0, d[6:0]});
    end

    // R4 compare with edges off
    wr_reg(2'd0, 8'h00);
    cnt = 16'h0700; idle(1);
    wr_reg(2'd1, 8'h07); wr_reg(2'd2, 8'h01);
    wr_reg(2'd0, 8'h10);
    cnt = 16'h0701; idle(1);
    rd_reg(2'd0, d); chk("R4", "no compare flag with edges off", {15'h0, d[7]}, 16'h0);
    chk("R4", "no compare action", {15'h0, pin_o}, {15'h0, exp_pin});

    // R6 overflow toggle, then match wins over overflow
    wr_reg(2'd0, 8'h00);
    cnt = 16'h0100; idle(1);
    wr_reg(2'd1, 8'h02); wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h16);
    ovf = 1'b1; idle(1); ovf = 1'b0;
    exp_pin = ~exp_pin;
    chk("R6", "overflow toggles pin", {15'h0, pin_o}, {15'h0, exp_pin});
    rd_reg(2'd0, d); chk("R6", "overflow sets no flag", {15'h0, d[7]}, 16'h0);
    begin
      logic [1:0] e;
      e = exp_pin ? 2'b11 : 2'b10;
      wr_reg(2'd0, {4'h1, e, 2'b10});
      cnt = 16'h0200; ovf = 1'b1; idle(1); ovf = 1'b0;
      exp_pin = cmp_act(exp_pin, e);
      chk("R6", "match beats overflow", {15'h0, pin_o}, {15'h0, exp_pin});
    end
    clear_flag();

    // R7 PWM without and with max duty
    wr_reg(2'd0, 8'h00);
    cnt = 16'h0300; idle(1);
    wr_reg(2'd1, 8'h03); wr_reg(2'd2, 8'h01);
    wr_reg(2'd0, 8'h24);
    cnt = 16'h0301; idle(1);
    exp_pin = ~exp_pin;
    chk("R7", "pwm match toggles", {15'h0, pin_o}, {15'h0, exp_pin});
    clear_flag();
    wr_reg(2'd0, 8'h29);
    cnt = 16'h0300; idle(1);
    cnt = 16'h0301; idle(1);
    chk("R7", "max duty overrides clear", {15'h0, pin_o}, 16'h1);
    exp_pin = 1'b1;
    clear_flag();

    // R9/R10 guarded clear observed through irq_o
    wr_reg(2'd0, 8'h00);
    pin = 1'b0; idle(3);
    wr_reg(2'd0, 8'h44);
    pin = 1'b1; idle(3);
    chk("R9", "irq with flag and enable", {15'h0, irq_o}, 16'h1);
    wr_reg(2'd0, 8'h44);
    chk("R10", "write 0 unarmed keeps flag", {15'h0, irq_o}, 16'h1);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'hC4);
    chk("R10", "write 1 keeps flag", {15'h0, irq_o}, 16'h1);
    wr_reg(2'd0, 8'h44);
    chk("R10", "write drops arm", {15'h0, irq_o}, 16'h1);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h44);
    chk("R11", "armed clear drops irq", {15'h0, irq_o}, 16'h0);

    // R12 event between arming read and clearing write
    wr_reg(2'd0, 8'h4C);
    cnt = 16'hBEEF; pin = ~pin; idle(3);
    chk("R12", "flag set before race", {15'h0, irq_o}, 16'h1);
    cnt = 16'hCAFE; pin = ~pin;
    rd_reg(2'd0, d);
    idle(2);
    wr_reg(2'd0, 8'h4C);
    chk("R12", "event after read keeps flag", {15'h0, irq_o}, 16'h1);
    rd_val(v); chk("R12", "race capture value", v, 16'hCAFE);

    // R12 event in same cycle as clearing write
    cnt = 16'hD00D; pin = ~pin;
    idle(1);
    rd_reg(2'd0, d);
    wr_reg(2'd0, 8'h4C);
    chk("R12", "event with write keeps flag", {15'h0, irq_o}, 16'h1);
    clear_flag();
    chk("R11", "clear after race", {15'h0, irq_o}, 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule